// File: doc/BRIEF.md
# YUV 4:2:2 Camera Port Capture

This block receives YUV 4:2:2 pixels from a camera port and delivers them as complete pixel pairs in one fixed order: luma 0, blue-difference chroma (U), luma 1, red-difference chroma (V). A pair is marked by a one-cycle strobe. Downstream logic never needs to know how the camera sends its bytes.

The port runs in one of two widths. In the wide mode two byte lanes carry luma and chroma in the same clock, so a pair takes two beats. In the narrow mode all bytes travel on the luma lane only. The clock then runs at twice the pixel rate and a pair takes four beats. A 2-bit order code tells the block which component arrives in which beat. The input pins can be sampled on either clock edge. The byte counter restarts whenever the line-valid input rises. If a line stops partway through a pair, that partial pair is dropped.

Top module: `vid422_capture`

## Requirements
- R1: While reset is held, and after its release until the first complete pair, `pix_vld` is 0 and all four pixel outputs are 0.
- R2: Narrow mode (`cfg_wide`=0), order code 0: the luma-lane bytes of a pair arrive as U, Y0, V, Y1.
- R3: Narrow mode, order code 1: the bytes arrive as V, Y0, U, Y1.
- R4: Narrow mode, order code 2: the bytes arrive as Y0, U, Y1, V.
- R5: Narrow mode, order code 3: the bytes arrive as Y0, V, Y1, U.
- R6: In narrow mode the chroma-lane input `vin_c` has no effect on the outputs.
- R7: Wide mode (`cfg_wide`=1) takes two beats per pair. Order bit 1 = 0 puts luma on `vin_y` and chroma on `vin_c`; bit 1 = 1 swaps the two lanes. Order bit 0 = 0 sends U in the first beat and V in the second; bit 0 = 1 sends V first. Y0 comes in the first beat and Y1 in the second.
- R8: When the last beat of a pair is set up before rising edge E1, `pix_vld` is high only in the cycle that follows edge E2, with the pair on the pixel outputs.
- R9: A rising edge of the sampled line-valid starts a new pair at its first beat, whatever bytes came before.
- R10: Beats left over at the end of a line that do not fill a pair produce no strobe.
- R11: With `cfg_fall_edge`=1 the inputs are taken at the falling clock edge. With 0 they are taken at the rising edge.
- R12: `pix_vld` is never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wide | input | 1 | 1 = two-lane bus, 0 = single-lane double-rate bus |
| cfg_order | input | 2 | Component order code |
| cfg_fall_edge | input | 1 | 1 = sample the pins on the falling edge |
| vin_y | input | DW | Luma lane (carries every byte in narrow mode) |
| vin_c | input | DW | Chroma lane |
| vin_lval | input | 1 | Line valid |
| pix_vld | output | 1 | One-cycle strobe for a complete pair |
| pix_y0 | output | DW | First luma of the pair |
| pix_u | output | DW | U chroma of the pair |
| pix_y1 | output | DW | Second luma of the pair |
| pix_v | output | DW | V chroma of the pair |

## Verification
Every order code is run in both widths. Y0, U, Y1 and V always carry different byte values, so if any two slots are swapped the output word is wrong. In the narrow runs the chroma lane carries changing junk, which shows it is ignored. Separate tests then cover:
- a three-byte fragment followed by a fresh line, which shows whether the counter restarts;
- a six-byte line, which shows whether leftover beats are dropped;
- a beat whose data changes in the middle of the clock period, sampled once in each edge mode, which shows which edge was used;
- a continuous wide line and a cycle-exact strobe probe, which show the pair spacing and the latency.

// File: rtl/vid422_pkg.sv
package vid422_pkg;

  // Slot index of each component in the normalized output pair
  typedef enum logic [1:0] {
    C_Y0 = 2'd0,
    C_U  = 2'd1,
    C_Y1 = 2'd2,
    C_V  = 2'd3
  } comp_e;

  // Chroma slot for the first (second=0) or second (second=1) chroma byte of a pair
  function automatic comp_e chroma_slot(input logic v_first, input logic second);
    return (v_first ^ second) ? C_V : C_U;
  endfunction

  // Narrow bus: slot taken by the byte at beat ph (0..3) for a given order code
  function automatic comp_e narrow_slot(input logic [1:0] order, input logic [1:0] ph);
    logic luma_here;
    luma_here = order[1] ? ~ph[0] : ph[0];
    if (luma_here) return ph[1] ? C_Y1 : C_Y0;
    return chroma_slot(order[0], ph[1]);
  endfunction

  // Wide bus: slot for the luma byte at beat ph0 (0..1)
  function automatic comp_e wide_luma_slot(input logic ph0);
    return ph0 ? C_Y1 : C_Y0;
  endfunction

  // Wide bus: slot for the chroma byte at beat ph0
  function automatic comp_e wide_chroma_slot(input logic [1:0] order, input logic ph0);
    return chroma_slot(order[0], ph0);
  endfunction

  // Whether beat ph completes a pair
  function automatic logic is_last_beat(input logic wide, input logic [1:0] ph);
    return wide ? ph[0] : (ph == 2'd3);
  endfunction

  // Beat counter advance
  function automatic logic [1:0] next_phase(input logic last, input logic [1:0] ph);
    return last ? 2'd0 : 2'(ph + 2'd1);
  endfunction

endpackage

// File: rtl/vid422_edge_sample.sv
module vid422_edge_sample #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fall_sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Falling-edge capture stage; the rising-edge stage picks either path
  logic [W-1:0] neg_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= '0;
    else        neg_q <= d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= fall_sel ? neg_q : d;
  end

endmodule

// File: rtl/vid422_pair_build.sv
module vid422_pair_build
  import vid422_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic [1:0]    order,
  input  logic [DW-1:0] s_y,
  input  logic [DW-1:0] s_c,
  input  logic          s_lv,
  output logic          pix_vld,
  output logic [DW-1:0] pix_y0,
  output logic [DW-1:0] pix_u,
  output logic [DW-1:0] pix_y1,
  output logic [DW-1:0] pix_v
);

  localparam int SLOTS = 4;

  logic          lv_q;
  logic          line_start;
  logic [1:0]    phase_q;
  logic [1:0]    eff_phase;
  logic          beat_last;
  logic [DW-1:0] luma_b;
  logic [DW-1:0] chroma_b;
  logic [DW-1:0] acc_q  [SLOTS];
  logic [DW-1:0] acc_nx [SLOTS];

  assign line_start = s_lv & ~lv_q;

  always_comb begin
    eff_phase = line_start ? 2'd0 : phase_q;
    beat_last = s_lv && is_last_beat(wide, eff_phase);
    luma_b    = order[1] ? s_c : s_y;
    chroma_b  = order[1] ? s_y : s_c;
    for (int i = 0; i < SLOTS; i++) acc_nx[i] = acc_q[i];
    if (wide) begin
      acc_nx[wide_luma_slot(eff_phase[0])]          = luma_b;
      acc_nx[wide_chroma_slot(order, eff_phase[0])] = chroma_b;
    end else begin
      acc_nx[narrow_slot(order, eff_phase)] = s_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q    <= 1'b0;
      phase_q <= 2'd0;
      pix_vld <= 1'b0;
      pix_y0  <= '0;
      pix_u   <= '0;
      pix_y1  <= '0;
      pix_v   <= '0;
      for (int i = 0; i < SLOTS; i++) acc_q[i] <= '0;
    end else begin
      lv_q    <= s_lv;
      pix_vld <= beat_last;
      if (s_lv) begin
        phase_q <= next_phase(beat_last, eff_phase);
        for (int i = 0; i < SLOTS; i++) acc_q[i] <= acc_nx[i];
      end
      if (beat_last) begin
        pix_y0 <= acc_nx[C_Y0];
        pix_u  <= acc_nx[C_U];
        pix_y1 <= acc_nx[C_Y1];
        pix_v  <= acc_nx[C_V];
      end
    end
  end

  // R1: quiet outputs under reset
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!pix_vld && pix_y0 == '0 && pix_v == '0);
    end
  end

  // R2..R5: a narrow pair needs four consecutive valid beats
  assert_narrow_four_beats_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && pix_vld) |-> ($past(s_lv, 1) && $past(s_lv, 2) && $past(s_lv, 3) && $past(s_lv, 4)));

  // R7: a wide pair needs two consecutive valid beats
  assert_wide_two_beats_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && pix_vld) |-> ($past(s_lv, 1) && $past(s_lv, 2)));

  // R9: a line start always consumes beat zero
  assert_line_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (phase_q == 2'd1));

  // R12: strobe is a single cycle
  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> !pix_vld);

endmodule

// File: rtl/vid422_capture.sv
module vid422_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wide,
  input  logic [1:0]    cfg_order,
  input  logic          cfg_fall_edge,
  input  logic [DW-1:0] vin_y,
  input  logic [DW-1:0] vin_c,
  input  logic          vin_lval,
  output logic          pix_vld,
  output logic [DW-1:0] pix_y0,
  output logic [DW-1:0] pix_u,
  output logic [DW-1:0] pix_y1,
  output logic [DW-1:0] pix_v
);

  localparam int SW = 2 * DW + 1;

  logic [SW-1:0] samp;
  logic [DW-1:0] s_y;
  logic [DW-1:0] s_c;
  logic          s_lv;

  vid422_edge_sample #(.W(SW)) u_sample (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_sel (cfg_fall_edge),
    .d        ({vin_lval, vin_y, vin_c}),
    .q        (samp)
  );

  assign {s_lv, s_y, s_c} = samp;

  vid422_pair_build #(.DW(DW)) u_build (
    .clk     (clk),
    .rst_n   (rst_n),
    .wide    (cfg_wide),
    .order   (cfg_order),
    .s_y     (s_y),
    .s_c     (s_c),
    .s_lv    (s_lv),
    .pix_vld (pix_vld),
    .pix_y0  (pix_y0),
    .pix_u   (pix_u),
    .pix_y1  (pix_y1),
    .pix_v   (pix_v)
  );

endmodule

// File: tb/vid422_capture_tb.sv
module vid422_capture_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  typedef struct packed {
    logic        wide;
    logic [1:0]  ord;
    logic [31:0] ybytes;
    logic [31:0] cbytes;
    logic [31:0] expw;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 32'hB2A1D4C3, 32'h5A5A5A5A, 32'hA1B2C3D4},
    '{1'b0, 2'd1, 32'hD4A1B2C3, 32'hFFEE0011, 32'hA1B2C3D4},
    '{1'b0, 2'd2, 32'hA1B2C3D4, 32'h01234567, 32'hA1B2C3D4},
    '{1'b0, 2'd3, 32'hA1D4C3B2, 32'h89ABCDEF, 32'hA1B2C3D4},
    '{1'b0, 2'd2, 32'h10203040, 32'h77777777, 32'h10203040},
    '{1'b1, 2'd0, 32'hA1C30000, 32'hB2D40000, 32'hA1B2C3D4},
    '{1'b1, 2'd1, 32'hA1C30000, 32'hD4B20000, 32'hA1B2C3D4},
    '{1'b1, 2'd2, 32'hB2D40000, 32'hA1C30000, 32'hA1B2C3D4},
    '{1'b1, 2'd3, 32'hD4B20000, 32'hA1C30000, 32'hA1B2C3D4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wide = 1'b0;
  logic [1:0]    cfg_order = 2'd0;
  logic          cfg_fall_edge = 1'b0;
  logic [DW-1:0] vin_y = '0;
  logic [DW-1:0] vin_c = '0;
  logic          vin_lval = 1'b0;
  logic          pix_vld;
  logic [DW-1:0] pix_y0, pix_u, pix_y1, pix_v;

  int n_checks = 0;
  int n_fail = 0;
  int cap_cnt = 0;
  logic [31:0] cap_word = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vid422_capture #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_order(cfg_order),
    .cfg_fall_edge(cfg_fall_edge), .vin_y(vin_y), .vin_c(vin_c), .vin_lval(vin_lval),
    .pix_vld(pix_vld), .pix_y0(pix_y0), .pix_u(pix_u), .pix_y1(pix_y1), .pix_v(pix_v)
  );

  // Pair monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (rst_n && pix_vld) begin
      cap_cnt++;
      cap_word = {pix_y0, pix_u, pix_y1, pix_v};
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic send_beat(input logic [7:0] y, input logic [7:0] c, input logic lv);
    @(posedge clk);
    #1;
    vin_y = y; vin_c = c; vin_lval = lv;
  endtask

  // Data a from the rising edge, data b from just after the falling edge
  task automatic send_split(input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    #1;
    vin_y = a; vin_lval = 1'b1;
    @(negedge clk);
    #1;
    vin_y = b;
  endtask

  task automatic settle();
    send_beat(8'h00, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    string tag;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(pix_vld == 1'b0, "R1", {31'd0, pix_vld}, 32'd0);
    check({pix_y0, pix_u, pix_y1, pix_v} == 32'd0, "R1", {pix_y0, pix_u, pix_y1, pix_v}, 32'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cap_cnt == 0 && pix_vld == 1'b0, "R1", cap_cnt, 0);

    // Table of orderings: R2 R3 R4 R5 R6 (narrow), R7 (wide)
    for (int k = 0; k < NV; k++) begin
      cfg_wide  = VECS[k].wide;
      cfg_order = VECS[k].ord;
      base = cap_cnt;
      for (int b = 0; b < (VECS[k].wide ? 2 : 4); b++)
        send_beat(VECS[k].ybytes[31 - 8*b -: 8], VECS[k].cbytes[31 - 8*b -: 8], 1'b1);
      settle();
      if (VECS[k].wide) tag = "R7";
      else case (VECS[k].ord)
        2'd0:    tag = "R2 R6";
        2'd1:    tag = "R3 R6";
        2'd2:    tag = "R4 R6";
        default: tag = "R5 R6";
      endcase
      check(cap_cnt == base + 1, tag, cap_cnt - base, 1);
      check(cap_word == VECS[k].expw, tag, cap_word, VECS[k].expw);
    end

    // R8: exact strobe cycle
    cfg_wide = 1'b0; cfg_order = 2'd2;
    base = cap_cnt;
    send_beat(8'h21, 8'h00, 1'b1);
    send_beat(8'h22, 8'h00, 1'b1);
    send_beat(8'h23, 8'h00, 1'b1);
    send_beat(8'h24, 8'h00, 1'b1);
    @(negedge clk);
    check(pix_vld == 1'b0, "R8", {31'd0, pix_vld}, 32'd0);
    @(negedge clk);
    check(pix_vld == 1'b0, "R8", {31'd0, pix_vld}, 32'd0);
    @(negedge clk);
    check(pix_vld == 1'b1, "R8", {31'd0, pix_vld}, 32'd1);
    check({pix_y0, pix_u, pix_y1, pix_v} == 32'h21222324, "R8", {pix_y0, pix_u, pix_y1, pix_v}, 32'h21222324);
    @(negedge clk);
    check(pix_vld == 1'b0, "R8 R12", {31'd0, pix_vld}, 32'd0);
    settle();
    check(cap_cnt == base + 1, "R8", cap_cnt - base, 1);

    // R10: six beats give one pair, leftovers dropped
    base = cap_cnt;
    send_beat(8'h31, 8'h00, 1'b1);
    send_beat(8'h32, 8'h00, 1'b1);
    send_beat(8'h33, 8'h00, 1'b1);
    send_beat(8'h34, 8'h00, 1'b1);
    send_beat(8'h35, 8'h00, 1'b1);
    send_beat(8'h36, 8'h00, 1'b1);
    settle();
    check(cap_cnt == base + 1, "R10", cap_cnt - base, 1);
    check(cap_word == 32'h31323334, "R10", cap_word, 32'h31323334);

    // R9: fragment then a new line restarts at beat zero
    base = cap_cnt;
    send_beat(8'hE1, 8'h00, 1'b1);
    send_beat(8'hE2, 8'h00, 1'b1);
    send_beat(8'hE3, 8'h00, 1'b1);
    send_beat(8'h00, 8'h00, 1'b0);
    send_beat(8'h01, 8'h00, 1'b1);
    send_beat(8'h02, 8'h00, 1'b1);
    send_beat(8'h03, 8'h00, 1'b1);
    send_beat(8'h04, 8'h00, 1'b1);
    settle();
    check(cap_cnt == base + 1, "R9", cap_cnt - base, 1);
    check(cap_word == 32'h01020304, "R9", cap_word, 32'h01020304);

    // R11: falling edge takes the early data, rising edge the late data
    cfg_fall_edge = 1'b1;
    base = cap_cnt;
    send_split(8'h61, 8'h71);
    send_split(8'h62, 8'h72);
    send_split(8'h63, 8'h73);
    send_split(8'h64, 8'h74);
    settle();
    check(cap_cnt == base + 1 && cap_word == 32'h61626364, "R11", cap_word, 32'h61626364);
    cfg_fall_edge = 1'b0;
    base = cap_cnt;
    send_split(8'h61, 8'h71);
    send_split(8'h62, 8'h72);
    send_split(8'h63, 8'h73);
    send_split(8'h64, 8'h74);
    settle();
    check(cap_cnt == base + 1 && cap_word == 32'h71727374, "R11", cap_word, 32'h71727374);

    // R12 R7: continuous wide line gives two spaced pairs
    cfg_wide = 1'b1; cfg_order = 2'd0;
    base = cap_cnt;
    send_beat(8'hA1, 8'hB2, 1'b1);
    send_beat(8'hC3, 8'hD4, 1'b1);
    send_beat(8'h11, 8'h22, 1'b1);
    send_beat(8'h33, 8'h44, 1'b1);
    settle();
    check(cap_cnt == base + 2, "R12", cap_cnt - base, 2);
    check(cap_word == 32'h11223344, "R7 R12", cap_word, 32'h11223344);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule